// File: doc/BRIEF.md
# Four-Channel Block Transfer Engine

This block moves words on behalf of four independent channels through one bus-master memory port. Each channel is armed by a start strobe together with a shared set of setup fields: transfer kind, source address, destination address, word count, a pointer to a follow-on descriptor, and a constant for fill jobs. A channel can copy one memory range to another, write a constant over a range, or serve an external I/O device. For I/O work the engine either reads a fixed device address and writes the data to memory, or, in fly-by mode, drives only the memory address and lets the device supply the data while an acknowledge line is raised.

All work is split into bursts of at most eight words. A fixed-priority arbiter picks the next channel, and it does so only between bursts. When a channel's count runs out and its descriptor pointer is nonzero, the engine fetches a four-word descriptor from memory and carries on with the new setup. The channel raises its done flag and a one-cycle interrupt pulse only after the last descriptor in its chain has finished. Addresses and counts are in words. Memory read data is expected in the cycle after the read request.

Top module: `dma4_engine`

## Requirements
- R1: A start strobe loads the shared setup into an idle channel and clears its done flag. A start strobe for a channel that is still busy is ignored and does not change its job.
- R2: Channel 0 has the highest priority and channel 3 the lowest. The choice between channels is made only between bursts, so a burst that has begun always completes before another channel gets the bus.
- R3: Kind code 0 (copy) reads words src..src+N-1 and writes them, in order, to dst..dst+N-1. Source and destination may be any word address, with no alignment limit.
- R4: A job of N words runs as ceil(N/8) bursts. Each burst holds min(remaining, 8) words. A copy burst issues all of its reads first and then all of its writes.
- R5: Kind code 1 (fill) writes the fill constant to dst..dst+N-1 and issues no memory reads.
- R6: Kind codes 2 and 3 are I/O kinds. On channels 0 and 1, an I/O job starts a burst only while that channel's request input is high. On channels 2 and 3, bit 1 of the kind code is ignored, so code 2 behaves as copy and code 3 behaves as fill.
- R7: Kind code 3 (fly-by) writes io_data to dst..dst+N-1 with no reads. The channel's acknowledge output is high in exactly the cycles of those memory writes.
- R8: Kind code 2 (dual-address I/O) reads the fixed address src once for each word and writes the results to incrementing destinations dst..dst+N-1.
- R9: When a channel's count reaches zero and its next pointer P is nonzero, the engine reads the four words at P..P+3 as, in order, next pointer, source, destination and count, and continues the channel with them. A next pointer of zero ends the chain.
- R10: After the final job of a chain, the channel's done flag goes high and its interrupt output pulses for exactly one cycle, once per chain.
- R11: After reset, no memory request is issued and every done, interrupt and acknowledge output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 4 | Per-channel start strobes |
| cfg_kind | input | 2 | Transfer kind: 0 copy, 1 fill, 2 dual-address I/O, 3 fly-by |
| cfg_src | input | 16 | Source word address |
| cfg_dst | input | 16 | Destination word address |
| cfg_cnt | input | 16 | Word count |
| cfg_next | input | 16 | Descriptor pointer, 0 means none |
| cfg_fill | input | 32 | Fill constant |
| dreq | input | 2 | External requests for channels 0 and 1 |
| dack | output | 2 | Fly-by acknowledges for channels 0 and 1 |
| io_data | input | 32 | Device data written during fly-by |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read |
| done | output | 4 | Per-channel completion flags |
| irq | output | 4 | Per-channel one-cycle completion pulses |

## Verification
The bench builds the engine with its default values: four channels, two of them with request pins, eight-word bursts and 16-bit addresses. Its memory model decodes only the low eight address bits. Copy lengths are swept from 1 to 19 words across all channels, at source offsets of both parities. This covers single partial bursts, one exact full burst and three-burst jobs. Fill lengths are swept from 1 to 12 words. A two-link chain, held-off requests, simultaneous starts and a start that arrives in the middle of a burst then exercise the descriptor walk, request gating and the arbitration points within a few hundred cycles each.

// File: rtl/dma4_pkg.sv
// Shared types for the block transfer engine.
// Assumes: kind encodings are fixed by the top-level port contract.
package dma4_pkg;
    typedef enum logic [1:0] {
        KIND_COPY = 2'd0,
        KIND_FILL = 2'd1,
        KIND_IO2A = 2'd2,
        KIND_FLY  = 2'd3
    } xfer_kind_e;

    typedef enum logic [2:0] {
        MV_IDLE, MV_RD, MV_RDW, MV_WR, MV_POST, MV_DLD
    } mv_state_e;
endpackage

// File: rtl/dma4_arbiter.sv
// Fixed-priority picker: lowest-numbered pending channel wins.
// Assumes: the caller samples the result only between bursts.
module dma4_arbiter #(
    parameter int NCH = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    output logic           gnt_any,
    output logic [CHW-1:0] gnt_idx
);
    // Scan from the lowest priority upward so the lowest index is kept last.
    always_comb begin
        gnt_any = |pend;
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) gnt_idx = CHW'(i);
        end
    end

    // R2: a grant never skips a higher-priority pending channel
    p_fixed_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> (pend[gnt_idx] &&
                     ((pend & ((NCH'(1) << gnt_idx) - NCH'(1))) == '0)));
endmodule

// File: rtl/dma4_channel.sv
// One channel's job state: kind, addresses, count, chain pointer, fill word.
// Assumes: upd and fin come from the mover only while this channel is busy.
module dma4_channel
    import dma4_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CW    = 16,
    parameter bit IO_OK = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_kind,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic [AW-1:0] cfg_next,
    input  logic [DW-1:0] cfg_fill,
    input  logic          upd,
    input  logic [AW-1:0] upd_src,
    input  logic [AW-1:0] upd_dst,
    input  logic [CW-1:0] upd_cnt,
    input  logic [AW-1:0] upd_next,
    input  logic          fin,
    output logic          busy,
    output xfer_kind_e    kind,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] nxt,
    output logic [DW-1:0] fill,
    output logic          done,
    output logic          irq
);
    // Arm on start when idle, follow mover write-backs, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            kind <= KIND_COPY;
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            nxt  <= '0;
            fill <= '0;
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                done <= 1'b0;
                kind <= IO_OK ? xfer_kind_e'(cfg_kind)
                              : xfer_kind_e'({1'b0, cfg_kind[0]});
                src  <= cfg_src;
                dst  <= cfg_dst;
                cnt  <= cfg_cnt;
                nxt  <= cfg_next;
                fill <= cfg_fill;
            end else if (upd) begin
                src <= upd_src;
                dst <= upd_dst;
                cnt <= upd_cnt;
                nxt <= upd_next;
                if (fin) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    irq  <= 1'b1;
                end
            end
        end
    end

    // R1: a start while busy cannot change the job kind
    p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(kind));
    // R10: the completion pulse lasts a single cycle
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R10: the pulse is always accompanied by the done flag
    p_irq_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

// File: rtl/dma4_mover.sv
// Bus-master sequencer: runs one burst (or one descriptor fetch) at a time.
// Assumes: read data returns one cycle after a read; memory never stalls;
// BURST >= 4 so a descriptor fits the staging buffer.
module dma4_mover
    import dma4_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CW    = 16,
    parameter int BURST = 8,
    parameter int CHW   = $clog2(NCH),
    parameter int IW    = $clog2(BURST),
    parameter int BW    = IW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gnt_any,
    input  logic [CHW-1:0] gnt_idx,
    input  xfer_kind_e     sel_kind,
    input  logic [AW-1:0]  sel_src,
    input  logic [AW-1:0]  sel_dst,
    input  logic [CW-1:0]  sel_cnt,
    input  logic [AW-1:0]  sel_next,
    input  logic [DW-1:0]  sel_fill,
    input  logic [DW-1:0]  io_data,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           fly_act,
    output logic [CHW-1:0] act_ch,
    output logic           upd_v,
    output logic [AW-1:0]  upd_src,
    output logic [AW-1:0]  upd_dst,
    output logic [CW-1:0]  upd_cnt,
    output logic [AW-1:0]  upd_next,
    output logic           fin_v
);
    mv_state_e      state;
    xfer_kind_e     cur_kind;
    logic [AW-1:0]  cur_src, cur_dst, cur_next;
    logic [CW-1:0]  cur_cnt;
    logic [DW-1:0]  cur_fill;
    logic [BW-1:0]  n_q, idx;
    logic           is_desc, rv_q;
    logic [IW-1:0]  ri_q;
    logic [DW-1:0]  stage [BURST];
    logic [BW-1:0]  wr_run;

    logic [AW-1:0]  idx_a, n_a;
    logic [CW-1:0]  n_c;
    logic           last_beat;

    assign idx_a     = AW'(idx);
    assign n_a       = AW'(n_q);
    assign n_c       = CW'(n_q);
    assign last_beat = (idx == n_q - 1'b1);

    // Burst length: the remaining count, clipped to the burst limit.
    function automatic logic [BW-1:0] burst_len(input logic [CW-1:0] c);
        return (c >= CW'(BURST)) ? BW'(BURST) : c[BW-1:0];
    endfunction

    // Sequencer: grant, read phase, write phase, write-back, chain fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MV_IDLE;
            cur_kind <= KIND_COPY;
            cur_src  <= '0;
            cur_dst  <= '0;
            cur_next <= '0;
            cur_cnt  <= '0;
            cur_fill <= '0;
            act_ch   <= '0;
            n_q      <= '0;
            idx      <= '0;
            is_desc  <= 1'b0;
        end else begin
            unique case (state)
                MV_IDLE: if (gnt_any) begin
                    act_ch   <= gnt_idx;
                    cur_kind <= sel_kind;
                    cur_src  <= sel_src;
                    cur_dst  <= sel_dst;
                    cur_cnt  <= sel_cnt;
                    cur_next <= sel_next;
                    cur_fill <= sel_fill;
                    n_q      <= burst_len(sel_cnt);
                    idx      <= '0;
                    is_desc  <= 1'b0;
                    if (sel_cnt == '0)
                        state <= MV_POST;
                    else if (sel_kind == KIND_FILL || sel_kind == KIND_FLY)
                        state <= MV_WR;
                    else
                        state <= MV_RD;
                end
                MV_RD: begin
                    idx <= idx + 1'b1;
                    if (last_beat) state <= MV_RDW;
                end
                MV_RDW: begin
                    idx   <= '0;
                    state <= is_desc ? MV_DLD : MV_WR;
                end
                MV_WR: begin
                    idx <= idx + 1'b1;
                    if (last_beat) begin
                        cur_cnt <= cur_cnt - n_c;
                        cur_dst <= cur_dst + n_a;
                        if (cur_kind == KIND_COPY) cur_src <= cur_src + n_a;
                        state <= MV_POST;
                    end
                end
                MV_POST: begin
                    if (cur_cnt == '0 && cur_next != '0) begin
                        is_desc <= 1'b1;
                        n_q     <= BW'(4);
                        idx     <= '0;
                        state   <= MV_RD;
                    end else begin
                        state <= MV_IDLE;
                    end
                end
                MV_DLD: begin
                    cur_next <= stage[0][AW-1:0];
                    cur_src  <= stage[1][AW-1:0];
                    cur_dst  <= stage[2][AW-1:0];
                    cur_cnt  <= stage[3][CW-1:0];
                    is_desc  <= 1'b0;
                    state    <= MV_POST;
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    // Read return path: capture each word one cycle after its request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= 1'b0;
            ri_q <= '0;
        end else begin
            rv_q <= (state == MV_RD);
            ri_q <= idx[IW-1:0];
            if (rv_q) stage[ri_q] <= mem_rdata;
        end
    end

    // Run length of back-to-back write cycles, watched by the burst check.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_run <= '0;
        else        wr_run <= (state == MV_WR) ? wr_run + 1'b1 : '0;
    end

    // Bus drive: address and data per phase and transfer kind.
    always_comb begin
        mem_req   = (state == MV_RD) || (state == MV_WR);
        mem_we    = (state == MV_WR);
        mem_addr  = cur_dst + idx_a;
        mem_wdata = stage[idx[IW-1:0]];
        if (state == MV_RD) begin
            if (is_desc)                    mem_addr = cur_next + idx_a;
            else if (cur_kind == KIND_IO2A) mem_addr = cur_src;
            else                            mem_addr = cur_src + idx_a;
        end
        if (cur_kind == KIND_FILL)     mem_wdata = cur_fill;
        else if (cur_kind == KIND_FLY) mem_wdata = io_data;
    end

    assign fly_act  = (state == MV_WR) && (cur_kind == KIND_FLY);
    assign upd_v    = (state == MV_POST);
    assign fin_v    = (state == MV_POST) && (cur_cnt == '0) && (cur_next == '0);
    assign upd_src  = cur_src;
    assign upd_dst  = cur_dst;
    assign upd_cnt  = cur_cnt;
    assign upd_next = cur_next;

    // R4: no write burst is longer than the burst limit
    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_run <= BW'(BURST));
    // R5: a fill job never reads memory outside descriptor fetches
    p_fill_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !is_desc && cur_kind == KIND_FILL) |-> mem_we);
    // R8: dual-address reads stay on one source address within a burst
    p_dual_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MV_RD && !is_desc && cur_kind == KIND_IO2A && idx != '0)
            |-> mem_addr == $past(mem_addr));
endmodule

// File: rtl/dma4_engine.sv
// Top of the block transfer engine: channel state, arbitration, one mover.
// Assumes: channels below NEXT own a request/acknowledge pair; the others
// run only memory kinds. Setup fields are shared and qualified by start.
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NEXT  = 2,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CW    = 16,
    parameter int BURST = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  start,
    input  logic [1:0]      cfg_kind,
    input  logic [AW-1:0]   cfg_src,
    input  logic [AW-1:0]   cfg_dst,
    input  logic [CW-1:0]   cfg_cnt,
    input  logic [AW-1:0]   cfg_next,
    input  logic [DW-1:0]   cfg_fill,
    input  logic [NEXT-1:0] dreq,
    output logic [NEXT-1:0] dack,
    input  logic [DW-1:0]   io_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [NCH-1:0]  done,
    output logic [NCH-1:0]  irq
);
    localparam int CHW = $clog2(NCH);

    logic [NCH-1:0] busy, pend;
    xfer_kind_e     ch_kind [NCH];
    logic [AW-1:0]  ch_src [NCH], ch_dst [NCH], ch_nxt [NCH];
    logic [CW-1:0]  ch_cnt [NCH];
    logic [DW-1:0]  ch_fill [NCH];

    logic           gnt_any, fly_act, upd_v, fin_v;
    logic [CHW-1:0] gnt_idx, act_ch;
    logic [AW-1:0]  upd_src, upd_dst, upd_next;
    logic [CW-1:0]  upd_cnt;

    for (genvar e = 0; e < NCH; e++) begin : g_ch
        localparam bit HAS_PIN = (e < NEXT);
        logic mine;
        assign mine = (act_ch == CHW'(e));

        dma4_channel #(.AW(AW), .DW(DW), .CW(CW), .IO_OK(HAS_PIN)) u_ch (
            .clk(clk), .rst_n(rst_n), .start(start[e]),
            .cfg_kind(cfg_kind), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
            .cfg_cnt(cfg_cnt), .cfg_next(cfg_next), .cfg_fill(cfg_fill),
            .upd(upd_v && mine), .upd_src(upd_src), .upd_dst(upd_dst),
            .upd_cnt(upd_cnt), .upd_next(upd_next), .fin(fin_v && mine),
            .busy(busy[e]), .kind(ch_kind[e]), .src(ch_src[e]),
            .dst(ch_dst[e]), .cnt(ch_cnt[e]), .nxt(ch_nxt[e]),
            .fill(ch_fill[e]), .done(done[e]), .irq(irq[e])
        );

        if (HAS_PIN) begin : g_pin
            // I/O kinds wait for the device request; memory kinds do not.
            assign pend[e] = busy[e] && (!ch_kind[e][1] || dreq[e]);
            assign dack[e] = fly_act && mine;
        end else begin : g_nopin
            assign pend[e] = busy[e];
        end
    end

    dma4_arbiter #(.NCH(NCH), .CHW(CHW)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .gnt_any(gnt_any), .gnt_idx(gnt_idx)
    );

    dma4_mover #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .BURST(BURST)) u_mv (
        .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_idx(gnt_idx),
        .sel_kind(ch_kind[gnt_idx]), .sel_src(ch_src[gnt_idx]),
        .sel_dst(ch_dst[gnt_idx]), .sel_cnt(ch_cnt[gnt_idx]),
        .sel_next(ch_nxt[gnt_idx]), .sel_fill(ch_fill[gnt_idx]),
        .io_data(io_data), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .fly_act(fly_act), .act_ch(act_ch),
        .upd_v(upd_v), .upd_src(upd_src), .upd_dst(upd_dst),
        .upd_cnt(upd_cnt), .upd_next(upd_next), .fin_v(fin_v)
    );

    // R7: acknowledge appears only during memory write cycles
    p_dack_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> (mem_req && mem_we));
    // R7: at most one device is acknowledged at a time
    p_dack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));
    // R10: completion pulses come from one channel at a time
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));
endmodule

// File: tb/dma4_engine_bench.sv
module dma4_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  start = '0;
    logic [1:0]  cfg_kind = '0;
    logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_cnt = '0, cfg_next = '0;
    logic [31:0] cfg_fill = '0, io_data = '0, mem_rdata;
    logic [1:0]  dreq = '0, dack;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  done, irq;

    always #2 clk = ~clk;

    dma4_engine u_dma4_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_kind(cfg_kind),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
        .cfg_next(cfg_next), .cfg_fill(cfg_fill), .dreq(dreq), .dack(dack),
        .io_data(io_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .irq(irq)
    );

    int errs = 0, nchk = 0;

    // Initial memory image, with two chain descriptors at 200 and 210.
    function automatic logic [31:0] seed(int k);
        case (k)
            200: return 32'd210;
            201: return 32'd40;
            202: return 32'd150;
            203: return 32'd5;
            210: return 32'd0;
            211: return 32'd60;
            212: return 32'd160;
            213: return 32'd9;
            default: return 32'hC0DE_0000 + 32'(k * 7);
        endcase
    endfunction

    logic [31:0] mem [256];
    logic        do_seed = 1'b0, mon_clr = 1'b0;
    logic [15:0] fix_addr = '0;
    int rd_cnt, wr_cnt, run, max_run, dack_cnt, dack_bad, raddr_bad, ord_n;
    int irq_cnt [4];
    int ord [8];

    // Memory model with one-cycle read latency, plus bus monitors.
    always @(posedge clk) begin
        if (do_seed) begin
            for (int k = 0; k < 256; k++) mem[k] <= seed(k);
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
        if (mon_clr) begin
            rd_cnt = 0; wr_cnt = 0; run = 0; max_run = 0; dack_cnt = 0;
            dack_bad = 0; raddr_bad = 0; ord_n = 0;
            for (int c = 0; c < 4; c++) irq_cnt[c] = 0;
        end else begin
            if (mem_req && !mem_we) begin
                rd_cnt++;
                if (mem_addr != fix_addr) raddr_bad++;
            end
            if (mem_req && mem_we) begin
                wr_cnt++; run++;
                if (run > max_run) max_run = run;
            end else run = 0;
            if (|dack) begin
                dack_cnt++;
                if (!(mem_req && mem_we)) dack_bad++;
            end
            for (int c = 0; c < 4; c++) if (irq[c]) begin
                irq_cnt[c]++;
                if (ord_n < 8) ord[ord_n] = c;
                ord_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reseed();
        @(negedge clk); do_seed = 1'b1; mon_clr = 1'b1;
        @(negedge clk); do_seed = 1'b0; mon_clr = 1'b0;
    endtask

    task automatic kick(input logic [3:0] mask, input logic [1:0] kind, input int src,
                        input int dst, input int cnt, input int nxt, input logic [31:0] fill);
        @(negedge clk);
        cfg_kind = kind; cfg_src = 16'(src); cfg_dst = 16'(dst);
        cfg_cnt = 16'(cnt); cfg_next = 16'(nxt); cfg_fill = fill; start = mask;
        @(negedge clk);
        start = '0;
    endtask

    task automatic wait_done(input int ch, input string req);
        int t = 0;
        while (!done[ch] && t < 3000) begin @(negedge clk); t++; end
        check(done[ch] == 1'b1, req, done[ch], 1);
        @(negedge clk);
    endtask

    // Compare a destination range with a source image, return mismatch count.
    function automatic int range_bad(int dst, int src, int n, bit fixed);
        int b = 0;
        for (int i = 0; i < n; i++)
            if (mem[dst + i] !== seed(fixed ? src : src + i)) b++;
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errs, nchk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: quiet after reset
        check(mem_req == 1'b0 && done == '0 && irq == '0 && dack == '0, "R11",
              {mem_req, done, irq, dack}, 0);
        rst_n = 1'b1;

        // R3 R4: copy sweep, every length 1..19 over all channels
        for (int n = 1; n <= 19; n++) begin
            int ch = n % 4;
            int sa = 3 + n;
            int da = 120 + n;
            int mb = range_bad(0, 0, 0, 0);
            reseed();
            kick(4'(1 << ch), 2'd0, sa, da, n, 0, '0);
            wait_done(ch, "R10");
            mb = range_bad(da, sa, n, 0);
            check(mb == 0, "R3", mb, 0);
            check(mem[da + n] === seed(da + n), "R3", mem[da + n], seed(da + n));
            check(rd_cnt == n && wr_cnt == n, "R4", rd_cnt, n);
            check(max_run == (n < 8 ? n : 8), "R4", max_run, (n < 8 ? n : 8));
            check(irq_cnt[ch] == 1, "R10", irq_cnt[ch], 1);
        end

        // R5: fill sweep
        for (int n = 1; n <= 12; n++) begin
            int ch = (n + 1) % 4;
            int b = 0;
            logic [31:0] fv = 32'hF00D_0000 + 32'(n);
            reseed();
            kick(4'(1 << ch), 2'd1, 9, 60, n, 0, fv);
            wait_done(ch, "R10");
            for (int i = 0; i < n; i++) if (mem[60 + i] !== fv) b++;
            check(b == 0, "R5", b, 0);
            check(rd_cnt == 0, "R5", rd_cnt, 0);
            check(mem[60 + n] === seed(60 + n), "R5", mem[60 + n], seed(60 + n));
        end

        // R6 R8: dual-address I/O on channel 0 waits for its request
        begin
            int mb;
            reseed();
            fix_addr = 16'd77;
            kick(4'b0001, 2'd2, 77, 130, 10, 0, '0);
            repeat (60) @(negedge clk);
            check(rd_cnt == 0 && wr_cnt == 0 && done[0] == 1'b0, "R6", rd_cnt + wr_cnt, 0);
            dreq[0] = 1'b1;
            wait_done(0, "R6");
            dreq[0] = 1'b0;
            mb = range_bad(130, 77, 10, 1);
            check(mb == 0, "R8", mb, 0);
            check(rd_cnt == 10 && raddr_bad == 0, "R8", raddr_bad, 0);
            fix_addr = '0;
        end

        // R6: on channel 2 the dual-address code runs as a plain copy
        begin
            int mb;
            reseed();
            kick(4'b0100, 2'd2, 30, 140, 6, 0, '0);
            wait_done(2, "R6");
            mb = range_bad(140, 30, 6, 0);
            check(mb == 0, "R6", mb, 0);
        end

        // R7: fly-by on channel 1
        begin
            int b = 0;
            reseed();
            io_data = 32'hBEEF_1234;
            dreq[1] = 1'b1;
            kick(4'b0010, 2'd3, 0, 90, 11, 0, '0);
            wait_done(1, "R7");
            dreq[1] = 1'b0;
            for (int i = 0; i < 11; i++) if (mem[90 + i] !== io_data) b++;
            check(b == 0, "R7", b, 0);
            check(dack_cnt == 11 && dack_bad == 0, "R7", dack_cnt, 11);
            check(rd_cnt == 0 && wr_cnt == 11, "R7", rd_cnt, 0);
        end

        // R9 R10: two-link chain, one completion for the whole chain
        begin
            int mb;
            reseed();
            kick(4'b0001, 2'd0, 10, 100, 3, 200, '0);
            wait_done(0, "R9");
            mb = range_bad(100, 10, 3, 0) + range_bad(150, 40, 5, 0) + range_bad(160, 60, 9, 0);
            check(mb == 0, "R9", mb, 0);
            check(rd_cnt == 25, "R9", rd_cnt, 25);
            check(irq_cnt[0] == 1, "R10", irq_cnt[0], 1);
        end

        // R2: simultaneous starts finish in priority order
        reseed();
        kick(4'b1011, 2'd0, 5, 100, 16, 0, '0);
        wait_done(3, "R2");
        check(ord_n == 3 && ord[0] == 0 && ord[1] == 1 && ord[2] == 3, "R2",
              ord[0] * 100 + ord[1] * 10 + ord[2], 13);

        // R2: a burst in progress is not preempted
        reseed();
        kick(4'b1000, 2'd0, 5, 100, 8, 0, '0);
        kick(4'b0001, 2'd0, 20, 150, 8, 0, '0);
        wait_done(0, "R2");
        check(ord_n == 2 && ord[0] == 3 && ord[1] == 0, "R2", ord[0] * 10 + ord[1], 30);

        // R1: start while busy is ignored; a fresh start clears done
        begin
            int mb;
            reseed();
            kick(4'b1000, 2'd0, 5, 120, 19, 0, '0);
            kick(4'b1000, 2'd1, 5, 170, 4, 0, 32'h1111_1111);
            wait_done(3, "R1");
            mb = range_bad(120, 5, 19, 0);
            check(mb == 0, "R1", mb, 0);
            check(mem[170] === seed(170), "R1", mem[170], seed(170));
            kick(4'b1000, 2'd1, 0, 60, 2, 0, 32'h2);
            check(done[3] == 1'b0, "R1", done[3], 0);
            wait_done(3, "R1");
        end

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule